// File: doc/BRIEF.md
# Unaligned multi-byte instruction fetch memory

This block is an on-chip byte-addressed instruction store. A fetch unit gives it one byte address per cycle and gets back, one cycle later, a 32-bit word whose lowest byte is the byte at that address. The higher bytes hold the bytes that follow it in memory. A variable-length instruction of one to three bytes can therefore be fetched whole in one read, at any byte alignment.

The storage is two banks of 16-bit words. One bank holds the even-numbered words and the other holds the odd-numbered words. Both banks are read in every cycle at the word-pair index. When the address points into the odd bank, the even bank's index is advanced by one, so that the even bank supplies the word after the odd one. A rotator then puts the bytes in order. Writes arrive one byte at a time on a separate port and go into one byte lane of one bank.

Top module: `ifm_fetch_mem`

## Requirements
- R1: While rst_ni is low, data_o is 0.
- R2: A read address sampled at a rising clock edge appears on data_o after that edge, with one cycle of latency. Byte k of data_o (bits 8k+7 to 8k) is the byte stored at address A+k, where A is the read address.
- R3: When address bit 0 is 0, all four bytes of data_o hold the stored bytes at A, A+1, A+2 and A+3.
- R4: When address bit 0 is 1, bytes 0 to 2 hold the stored bytes at A, A+1 and A+2, and byte 3 (bits 31 to 24) reads as 0.
- R5: Addresses past the top of memory wrap modulo 2^ADDR_W. A fetch near the end of memory continues with the bytes at address 0.
- R6: When wr_en_i is high at a rising edge, the byte at wr_addr_i becomes wr_data_i. Every other stored byte keeps its value.
- R7: If a read in the same cycle as a write covers the written byte, it returns the new byte.
- R8: A read of an address issued in the cycle after a write to it returns the new byte.
- R9: While the read address is held and no write occurs, data_o does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_addr_i | input | ADDR_W | Byte address of the fetch |
| data_o | output | 32 | Fetched bytes, lowest byte at the requested address |
| wr_en_i | input | 1 | Byte write enable |
| wr_addr_i | input | ADDR_W | Byte address of the write |
| wr_data_i | input | 8 | Byte to write |

## Verification
A wrong bank index, such as an even bank that is not advanced, shows up in the next cycle. In that cycle, bytes 2 and 3 of an address with bit 1 set come from the wrong word, so the sweep over every alignment catches it at the first such address. A wrong rotation or bank select scrambles the byte order in the first cycle after the read. A broken byte lane or a missing write-first bypass corrupts a neighbouring byte or returns the stale byte. Either fault appears one cycle after the write. The cycle-by-cycle reference model compares every output word, so each fault is reported in the cycle in which it first shows.

// File: rtl/ifm_pkg.sv
package ifm_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned FETCH_W = 32;
  localparam int unsigned NUM_BANKS = 2;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [FETCH_W-1:0] fetch_t;
endpackage

// File: rtl/ifm_addr_gen.sv
module ifm_addr_gen #(
  parameter int unsigned ADDR_W = 10,
  localparam int unsigned IDX_W = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output logic [IDX_W-1:0]  even_idx_o,
  output logic [IDX_W-1:0]  odd_idx_o,
  output logic [1:0]        bank_we_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic              wr_lane_o
);
  logic [IDX_W-1:0] pair_idx;

  assign pair_idx = rd_addr_i[ADDR_W-1:2];
  // odd-bank start: even bank must supply the following word pair (wraps)
  assign even_idx_o = pair_idx + IDX_W'(rd_addr_i[1]);
  assign odd_idx_o  = pair_idx;

  assign wr_idx_o  = wr_addr_i[ADDR_W-1:2];
  assign wr_lane_o = wr_addr_i[0];
  assign bank_we_o = {wr_en_i & wr_addr_i[1], wr_en_i & ~wr_addr_i[1]};
endmodule

// File: rtl/ifm_bank.sv
module ifm_bank
  import ifm_pkg::*;
#(
  parameter int unsigned IDX_W = 8,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_lane_i,
  input  byte_t            wr_byte_i,
  output word_t            rd_word_o
);
  word_t mem_q [DEPTH];
  word_t rd_q;
  word_t rd_raw;
  word_t rd_fwd;
  logic  primed_q;

  assign rd_raw = mem_q[rd_idx_i];

  always_comb begin
    rd_fwd = rd_raw;
    if (wr_en_i && (wr_idx_i == rd_idx_i)) begin
      if (wr_lane_i) rd_fwd[15:8] = wr_byte_i;
      else           rd_fwd[7:0]  = wr_byte_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      if (wr_lane_i) mem_q[wr_idx_i][15:8] <= wr_byte_i;
      else           mem_q[wr_idx_i][7:0]  <= wr_byte_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q     <= '0;
      primed_q <= 1'b0;
    end else begin
      rd_q     <= rd_fwd;
      primed_q <= 1'b1;
    end
  end

  assign rd_word_o = rd_q;

  // R9: held index with no write keeps the read word
  a_r9_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed_q && !wr_en_i && !$past(wr_en_i) && rd_idx_i == $past(rd_idx_i)) |=> $stable(rd_word_o));
endmodule

// File: rtl/ifm_align.sv
module ifm_align
  import ifm_pkg::*;
(
  input  word_t  even_word_i,
  input  word_t  odd_word_i,
  input  logic   bank_sel_i,
  input  logic   byte_off_i,
  output fetch_t data_o
);
  word_t  lo_word;
  word_t  hi_word;
  fetch_t window;

  assign lo_word = bank_sel_i ? odd_word_i  : even_word_i;
  assign hi_word = bank_sel_i ? even_word_i : odd_word_i;
  assign window  = {hi_word, lo_word};
  // odd byte start: only three bytes are reachable, top byte forced to zero
  assign data_o  = byte_off_i ? {8'h00, window[31:8]} : window;
endmodule

// File: rtl/ifm_fetch_mem.sv
module ifm_fetch_mem
  import ifm_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [31:0]       data_o,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i
);
  localparam int unsigned IDX_W = ADDR_W - 2;
  typedef logic [ADDR_W-1:0] addr_t;

  logic [IDX_W-1:0] bank_idx [NUM_BANKS];
  logic [1:0]       bank_we;
  logic [IDX_W-1:0] wr_idx;
  logic             wr_lane;
  word_t            bank_word [NUM_BANKS];
  logic [1:0]       lo_q;
  logic             primed_q;

  ifm_addr_gen #(.ADDR_W(ADDR_W)) u_addr_gen (
    .rd_addr_i  (rd_addr_i),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .even_idx_o (bank_idx[0]),
    .odd_idx_o  (bank_idx[1]),
    .bank_we_o  (bank_we),
    .wr_idx_o   (wr_idx),
    .wr_lane_o  (wr_lane)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    ifm_bank #(.IDX_W(IDX_W)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rd_idx_i  (bank_idx[b]),
      .wr_en_i   (bank_we[b]),
      .wr_idx_i  (wr_idx),
      .wr_lane_i (wr_lane),
      .wr_byte_i (wr_data_i),
      .rd_word_o (bank_word[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q     <= 2'b00;
      primed_q <= 1'b0;
    end else begin
      lo_q     <= rd_addr_i[1:0];
      primed_q <= 1'b1;
    end
  end

  ifm_align u_align (
    .even_word_i (bank_word[0]),
    .odd_word_i  (bank_word[1]),
    .bank_sel_i  (lo_q[1]),
    .byte_off_i  (lo_q[0]),
    .data_o      (data_o)
  );

  // R7: same-cycle write to the first fetched byte is forwarded
  a_r7_write_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == rd_addr_i) |=> data_o[7:0] == $past(wr_data_i));

  // R4: odd start leaves the top byte empty
  a_r4_odd_top_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_addr_i[0] |=> data_o[31:24] == 8'h00);

  // R2: stepping the address by one slides the bytes down by one lane
  a_r2_slide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed_q && !wr_en_i && !$past(wr_en_i) && (rd_addr_i - addr_t'(1)) == $past(rd_addr_i))
    |=> data_o[7:0] == $past(data_o[15:8]));
endmodule

// File: tb/ifm_fetch_mem_bench.sv
module ifm_fetch_mem_bench;
  localparam int ADDR_W = 10;
  localparam int DEPTH = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [31:0]       data;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [7:0]        wr_data = '0;

  int checks = 0;
  int fails = 0;
  logic [7:0] ref_mem [DEPTH];

  always #2 clk = ~clk;

  ifm_fetch_mem #(.ADDR_W(ADDR_W)) u_ifm_fetch_mem (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .rd_addr_i (rd_addr),
    .data_o    (data),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data)
  );

  function automatic logic [31:0] model(input int a);
    logic [31:0] r;
    for (int k = 0; k < 4; k++)
      r[8*k +: 8] = (k == 3 && (a % 2) == 1) ? 8'h00 : ref_mem[(a + k) % DEPTH];
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, update model at posedge (write-first), compare at next negedge
  task automatic step(input int ra, input logic we, input int wa, input logic [7:0] wd,
                      input string tag);
    logic [31:0] exp;
    rd_addr = ADDR_W'(ra);
    wr_en   = we;
    wr_addr = ADDR_W'(wa);
    wr_data = wd;
    @(posedge clk);
    if (we) ref_mem[wa % DEPTH] = wd;
    exp = model(ra % DEPTH);
    @(negedge clk);
    if (tag != "") check(tag, data, exp);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] lfsr;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    check("R1 reset", data, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // fill every byte
    lfsr = 8'h5a;
    for (int i = 0; i < DEPTH; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(i, 1'b1, i, lfsr ^ 8'(i), "");
    end

    // R2 R3 R4: sweep every alignment
    for (int a = 0; a < 64; a++) step(a, 1'b0, 0, 8'h00, (a % 2) ? "R4 odd" : "R3 even");
    for (int a = 400; a > 380; a -= 3) step(a, 1'b0, 0, 8'h00, "R2 scattered");

    // R5: wrap at top
    for (int a = DEPTH - 4; a < DEPTH; a++) step(a, 1'b0, 0, 8'h00, "R5 wrap");

    // R6: single byte write, neighbours unchanged
    step(0, 1'b1, 101, 8'hc3, "R6 write");
    for (int a = 96; a < 104; a++) step(a, 1'b0, 0, 8'h00, "R6 neighbours");
    step(0, 1'b1, 1023, 8'h7e, "R6 write top");
    step(1022, 1'b0, 0, 8'h00, "R6 top read");

    // R7: same-cycle write inside window, all lanes and banks
    for (int k = 0; k < 4; k++) step(200, 1'b1, 200 + k, 8'(8'h10 + k), "R7 write first");
    for (int k = 0; k < 3; k++) step(203, 1'b1, 203 + k, 8'(8'h20 + k), "R7 write first odd");
    step(1022, 1'b1, 0, 8'h99, "R7 wrap write first");

    // R8: write then read next cycle
    for (int k = 0; k < 4; k++) begin
      step(0, 1'b1, 300 + k, 8'(8'ha0 + k), "");
      step(300 + k, 1'b0, 0, 8'h00, "R8 next cycle");
    end

    // R9: hold address, no writes
    step(513, 1'b0, 0, 8'h00, "R9 hold");
    held = data;
    for (int k = 0; k < 5; k++) begin
      step(513, 1'b0, 0, 8'h00, "R9 hold");
      check("R9 stable", data, held);
    end

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule